// File: doc/BRIEF.md
# Audio Stream Run-State Controller

This block is the control state machine for one direction (transmit or receive) of an audio serial port. It takes configure strobes and trigger commands from the host side and decides when the serializer or deserializer may run. It also watches block-completion and underrun/overrun events coming back from the serial engine and the attached queue. The queue storage itself is not part of the block: the controller only sees its empty and full flags, and can ask for the queue to be flushed.

Each command strobe produces exactly one result pulse, either accept or reject, one cycle later. The reported state, the flush pulse and the result come from registers and change on the same clock edge. The engine enable follows the state directly.

Top module: `stream_run_ctl`

## Requirements
- R1: While reset is held and after it is released, `state` is 0. The state codes are: 0 not-ready, 1 ready, 2 running, 3 stopping, 4 error. `cmd_ack`, `cmd_nak`, `q_flush` and `eng_en` are low.
- R2: A configure strobe is accepted only in not-ready or ready. It moves the block to ready, or to not-ready when `cfg_rate_zero` is set. In any other state it is rejected and leaves the state alone. When `cmd_vld` and `cfg_vld` arrive together, only the command is acted on.
- R3: START (opcode 0) is accepted only in ready and moves the block to running. For transmit (`dir_tx`=1) the queue must not be empty. For receive it must not be full. Otherwise START is rejected.
- R4: STOP (opcode 1) is accepted only in running and moves the block to stopping. The next `blk_end` returns it to ready, and a later START runs again.
- R5: DRAIN (opcode 2) is accepted only in running and moves the block to stopping. For transmit, it returns to ready only on a `blk_end` seen while `q_empty` is high. For receive, any `blk_end` returns it to ready.
- R6: DROP (opcode 3) is accepted in every state except not-ready. It moves the block to ready at once and raises `q_flush` for exactly one cycle. In not-ready it is rejected.
- R7: An `xrun` pulse in running or stopping moves the block to error. It takes priority over a command in the same cycle, and that command is rejected. `xrun` in any other state has no effect. PREPARE (opcode 4) is accepted only in error and moves the block to ready.
- R8: Every strobe cycle yields exactly one of `cmd_ack`/`cmd_nak` on the next cycle. Opcodes 5 to 7 are always rejected. A rejected command does not change the state.
- R9: `eng_en` is high exactly while the state is running or stopping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_vld | input | 1 | Trigger command strobe |
| cmd_op | input | 3 | Trigger opcode |
| cfg_vld | input | 1 | Configure strobe |
| cfg_rate_zero | input | 1 | Configured frame rate is zero |
| dir_tx | input | 1 | 1 = transmit direction, 0 = receive |
| q_empty | input | 1 | Attached queue holds no block |
| q_full | input | 1 | Attached queue has no free block |
| blk_end | input | 1 | Current block finished on the serial side |
| xrun | input | 1 | Transmit underrun or receive overrun pulse |
| state | output | 3 | Current run state |
| eng_en | output | 1 | Serial engine enable |
| q_flush | output | 1 | One-cycle request to discard the queue |
| cmd_ack | output | 1 | Previous strobe accepted |
| cmd_nak | output | 1 | Previous strobe rejected |

## Verification
The bench concentrates on the exit from stopping. A design that treated drain as stop would return to ready while transmit blocks were still queued. One that ignored the drain mode in receive would stay stuck in stopping. It checks START against an empty transmit queue and a full receive queue, where a missing guard would start the engine with nothing to send or nowhere to store. It checks an `xrun` that coincides with a command, where wrong priority would leave the block running after a fault. It also checks simultaneous configure and command strobes, and a flush that must last one cycle only.

// File: rtl/stream_run_ctl.sv
module stream_run_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_vld,
  input  logic [2:0] cmd_op,
  input  logic       cfg_vld,
  input  logic       cfg_rate_zero,
  input  logic       dir_tx,
  input  logic       q_empty,
  input  logic       q_full,
  input  logic       blk_end,
  input  logic       xrun,
  output logic [2:0] state,
  output logic       eng_en,
  output logic       q_flush,
  output logic       cmd_ack,
  output logic       cmd_nak
);

  localparam logic [2:0] S_NRDY = 3'd0, S_RDY = 3'd1, S_RUN = 3'd2,
                         S_STP  = 3'd3, S_ERR = 3'd4;
  localparam logic [2:0] OP_START = 3'd0, OP_STOP = 3'd1, OP_DRAIN = 3'd2,
                         OP_DROP  = 3'd3, OP_PREP = 3'd4;

  logic [2:0] st, nxt;
  logic       drain_q, drain_n, ok, flush_n;
  logic       active, strobe, room;

  assign active = (st == S_RUN) || (st == S_STP);
  assign strobe = cmd_vld || cfg_vld;
  assign room   = dir_tx ? !q_empty : !q_full;

  always_comb begin
    nxt     = st;
    ok      = 1'b0;
    flush_n = 1'b0;
    drain_n = drain_q;
    if (active && xrun) begin
      nxt = S_ERR;
    end else begin
      if (st == S_STP && blk_end && (!drain_q || !dir_tx || q_empty))
        nxt = S_RDY;
      if (cmd_vld) begin
        case (cmd_op)
          OP_START: if (st == S_RDY && room) begin
            ok = 1'b1; nxt = S_RUN;
          end
          OP_STOP: if (st == S_RUN) begin
            ok = 1'b1; nxt = S_STP; drain_n = 1'b0;
          end
          OP_DRAIN: if (st == S_RUN) begin
            ok = 1'b1; nxt = S_STP; drain_n = 1'b1;
          end
          OP_DROP: if (st != S_NRDY) begin
            ok = 1'b1; nxt = S_RDY; flush_n = 1'b1;
          end
          OP_PREP: if (st == S_ERR) begin
            ok = 1'b1; nxt = S_RDY;
          end
          default: ok = 1'b0;
        endcase
      end else if (cfg_vld && (st == S_NRDY || st == S_RDY)) begin
        ok  = 1'b1;
        nxt = cfg_rate_zero ? S_NRDY : S_RDY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_NRDY;
      drain_q <= 1'b0;
      q_flush <= 1'b0;
      cmd_ack <= 1'b0;
      cmd_nak <= 1'b0;
    end else begin
      st      <= nxt;
      drain_q <= drain_n;
      q_flush <= flush_n;
      cmd_ack <= strobe && ok;
      cmd_nak <= strobe && !ok;
    end
  end

  assign state  = st;
  assign eng_en = active;

endmodule

// File: rtl/stream_run_ctl_chk.sv
module stream_run_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_vld,
  input logic       blk_end,
  input logic       xrun,
  input logic [2:0] state,
  input logic       q_flush,
  input logic       cmd_ack,
  input logic       cmd_nak
);

  p_state_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd4);

  p_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ack, cmd_nak}));

  p_nak_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !blk_end && !xrun) |=> (!cmd_nak || state == $past(state)));

  p_flush_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |-> (state == 3'd1 && cmd_ack));

  p_run_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && $past(state) != 3'd2) |-> $past(state) == 3'd1);

  p_err_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && $past(state) != 3'd4) |->
      ($past(state) == 3'd2 || $past(state) == 3'd3));

endmodule

bind stream_run_ctl stream_run_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .blk_end(blk_end),
  .xrun(xrun), .state(state), .q_flush(q_flush),
  .cmd_ack(cmd_ack), .cmd_nak(cmd_nak)
);

// File: tb/stream_run_ctl_bench.sv
`timescale 1ns/1ps
module stream_run_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic cmd_vld = 0, cfg_vld = 0, cfg_rate_zero = 0, dir_tx = 1;
  logic q_empty = 1, q_full = 0, blk_end = 0, xrun = 0;
  logic [2:0] cmd_op = 0;
  logic [2:0] state;
  logic eng_en, q_flush, cmd_ack, cmd_nak;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stream_run_ctl u_stream_run_ctl (.*);

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(bit cv, logic [2:0] op, bit fv, bit fz, bit be, bit xr);
    @(negedge clk);
    cmd_vld = cv; cmd_op = op; cfg_vld = fv; cfg_rate_zero = fz;
    blk_end = be; xrun = xr;
    @(posedge clk); #1;
    cmd_vld = 0; cfg_vld = 0; cfg_rate_zero = 0; blk_end = 0; xrun = 0;
  endtask

  task automatic expect_out(string req, int st, bit ack, bit nak);
    check({req, " state"}, state, st);
    check({req, " ack"}, cmd_ack, ack);
    check({req, " nak"}, cmd_nak, nak);
    check({req, " en R9"}, eng_en, (st == 2 || st == 3));
  endtask

  task automatic t_reset;
    check("R1 state", state, 0);
    check("R1 en", eng_en, 0);
    check("R1 flush", q_flush, 0);
    check("R1 ack", cmd_ack, 0);
    check("R1 nak", cmd_nak, 0);
  endtask

  task automatic t_config;
    step(1, 0, 0, 0, 0, 0); expect_out("R8 start in notready", 0, 0, 1);
    step(1, 3, 0, 0, 0, 0); expect_out("R6 drop in notready", 0, 0, 1);
    step(0, 0, 1, 1, 0, 0); expect_out("R2 cfg zero", 0, 1, 0);
    step(0, 0, 1, 0, 0, 0); expect_out("R2 cfg", 1, 1, 0);
    step(0, 0, 1, 1, 0, 0); expect_out("R2 cfg zero from ready", 0, 1, 0);
    step(0, 0, 1, 0, 0, 0); expect_out("R2 cfg again", 1, 1, 0);
  endtask

  task automatic t_start_tx;
    dir_tx = 1; q_empty = 1;
    step(1, 0, 0, 0, 0, 0); expect_out("R3 start tx empty", 1, 0, 1);
    q_empty = 0;
    step(1, 0, 0, 0, 0, 0); expect_out("R3 start tx", 2, 1, 0);
    step(0, 0, 1, 0, 0, 0); expect_out("R2 cfg in running", 2, 0, 1);
    step(1, 4, 0, 0, 0, 0); expect_out("R7 prepare in running", 2, 0, 1);
    step(1, 6, 0, 0, 0, 0); expect_out("R8 bad opcode", 2, 0, 1);
  endtask

  task automatic t_stop;
    step(1, 1, 0, 0, 0, 0); expect_out("R4 stop", 3, 1, 0);
    step(0, 0, 0, 0, 0, 0); expect_out("R4 wait block", 3, 0, 0);
    step(0, 0, 0, 0, 1, 0); expect_out("R4 block end", 1, 0, 0);
    step(1, 0, 0, 0, 0, 0); expect_out("R4 resume", 2, 1, 0);
  endtask

  task automatic t_drain_tx;
    q_empty = 0;
    step(1, 2, 0, 0, 0, 0); expect_out("R5 drain tx", 3, 1, 0);
    step(0, 0, 0, 0, 1, 0); expect_out("R5 blocks left", 3, 0, 0);
    q_empty = 1;
    step(0, 0, 0, 0, 1, 0); expect_out("R5 drained", 1, 0, 0);
  endtask

  task automatic t_drain_rx;
    dir_tx = 0; q_empty = 0; q_full = 1;
    step(1, 0, 0, 0, 0, 0); expect_out("R3 start rx full", 1, 0, 1);
    q_full = 0;
    step(1, 0, 0, 0, 0, 0); expect_out("R3 start rx", 2, 1, 0);
    step(1, 2, 0, 0, 0, 0); expect_out("R5 drain rx", 3, 1, 0);
    step(0, 0, 0, 0, 1, 0); expect_out("R5 rx as stop", 1, 0, 0);
    dir_tx = 1;
  endtask

  task automatic t_drop;
    q_empty = 0;
    step(1, 0, 0, 0, 0, 0); expect_out("R6 setup", 2, 1, 0);
    step(1, 3, 0, 0, 0, 0); expect_out("R6 drop", 1, 1, 0);
    check("R6 flush", q_flush, 1);
    step(0, 0, 0, 0, 0, 0);
    check("R6 flush single", q_flush, 0);
    step(1, 3, 0, 0, 0, 0); expect_out("R6 drop in ready", 1, 1, 0);
    check("R6 flush in ready", q_flush, 1);
  endtask

  task automatic t_error;
    step(1, 0, 0, 0, 0, 0); expect_out("R7 setup", 2, 1, 0);
    step(1, 1, 0, 0, 0, 1); expect_out("R7 xrun beats stop", 4, 0, 1);
    step(1, 1, 0, 0, 0, 0); expect_out("R7 stop in error", 4, 0, 1);
    step(0, 0, 1, 0, 0, 0); expect_out("R2 cfg in error", 4, 0, 1);
    step(1, 4, 0, 0, 0, 0); expect_out("R7 prepare", 1, 1, 0);
    step(0, 0, 0, 0, 0, 1); expect_out("R7 xrun in ready", 1, 0, 0);
  endtask

  task automatic t_both;
    step(1, 0, 1, 1, 0, 0); expect_out("R2 cmd wins", 2, 1, 0);
    step(1, 3, 0, 0, 0, 0); expect_out("R6 cleanup", 1, 1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1 t_reset();
    t_config();
    t_start_tx();
    t_stop();
    t_drain_tx();
    t_drain_rx();
    t_drop();
    t_error();
    t_both();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule